// File: doc/BRIEF.md
# External Oscillator Failure Monitor with Internal Fallback

This block guards the system clock selection against a dead external high-speed oscillator. Running in a fast monitor clock domain, it samples the raw external oscillator and a divided internal reference as ordinary data. Each sample passes through a synchronizer and then a rising-edge detector. The block counts external rising edges over a fixed window of reference periods. An armed window that ends with too few external edges is a failure.

A failure forces the system clock selection to the internal oscillator and takes the PLL out of use, so the clock the system gets is the raw internal frequency. It also raises a sticky interrupt flag. When a configuration input routes the event that way, it raises a sticky non-maskable interrupt line as well. Software must write a clear before a request for the external source or the PLL is honoured again. While the failure flag is set, such requests are refused. The clock multiplexer itself sits outside this block and only consumes the selection code and the bypass flag.

Top module: `xosc_guard`

## Requirements
- R1: After reset the selection output is the internal code 0, pll_bypass is 1, and irq_fail and nmi_fail are 0.
- R2: With no failure flag set, sel_src takes the requested code one clock edge after the request. The codes are 0 for internal, 1 for external and 2 for PLL, and the reserved code 3 selects internal. pll_bypass is 0 only while sel_src is 2.
- R3: One window lasts 64 synchronized reference rising edges. An armed window with at least 8 external rising edges never trips. An external clock that gives exactly 8 edges per window runs indefinitely without a failure.
- R4: An armed window with fewer than 8 external rising edges declares a failure. irq_fail then rises on the same edge at which sel_src becomes 0 and pll_bypass becomes 1.
- R5: irq_fail stays high after the external clock recovers, and falls one edge after a clear pulse.
- R6: nmi_fail rises together with irq_fail only when nmi_route is high at the failure. The clear pulse also drops it.
- R7: While irq_fail is high, requests for code 1 or 2 are refused, and sel_src stays 0.
- R8: Once the flag has been cleared, a pending PLL request is applied one edge after irq_fail falls.
- R9: No failure is declared while mon_en is low. No failure is declared before ext_rdy has been high for one complete window, so a dead external clock with ext_rdy low never trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast monitor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Monitor enable |
| ext_rdy | input | 1 | External oscillator ready indication |
| nmi_route | input | 1 | Route a failure to the non-maskable interrupt line |
| ext_clk_raw | input | 1 | Raw external oscillator, sampled as data |
| ref_clk_raw | input | 1 | Raw divided internal reference, sampled as data |
| req_src | input | 2 | Requested system clock source code |
| flag_clr | input | 1 | Single-cycle clear write for the failure flags |
| sel_src | output | 2 | Selected source code (0 internal, 1 external, 2 PLL) |
| pll_bypass | output | 1 | High when the PLL output is not in use |
| irq_fail | output | 1 | Sticky failure interrupt flag |
| nmi_fail | output | 1 | Sticky non-maskable failure interrupt |

## Verification
A request reaches sel_src on the first edge after it is driven. A clear drops the flags on the first edge and lets a pending request through on the second, so the bench drives on the falling edge and samples on the next one or two falling edges. A failure shows up two edges after the synchronized reference edge that closes a short window. Because that instant depends on the window phase, the bench polls irq_fail within a bound of two windows plus the synchronizer depth, and checks sel_src, pll_bypass and nmi_fail on the same sample. The no-trip cases, including exactly eight edges per window, are checked after several complete windows have elapsed.

// File: rtl/xosc_guard_pkg.sv
package xosc_guard_pkg;
   localparam logic [1:0] SRC_INT = 2'd0;
   localparam logic [1:0] SRC_EXT = 2'd1;
   localparam logic [1:0] SRC_PLL = 2'd2;

   // reserved code folds onto the internal oscillator
   function automatic logic [1:0] legal_src(input logic [1:0] req);
      return (req == 2'd3) ? SRC_INT : req;
   endfunction
endpackage

// File: rtl/xg_sync.sv
module xg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("xg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/xg_window.sv
module xg_window #(
   parameter int WIN_REFS    = 64,
   parameter int MIN_EDGES   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic rdy,
   input  logic ext_raw,
   input  logic ref_raw,
   output logic fail_o,
   output logic armed_o
);
   localparam int RW = (WIN_REFS > 2) ? $clog2(WIN_REFS) : 1;
   localparam int EW = $clog2(MIN_EDGES + 1);
   localparam logic [RW-1:0] REF_LAST = RW'(WIN_REFS - 1);
   localparam logic [EW:0]   EDGE_MIN = (EW+1)'(MIN_EDGES);

   logic ext_s, ref_s, ext_p, ref_p;
   logic ext_rise, ref_rise, win_end, short_win;
   logic [RW-1:0] ref_cnt;
   logic [EW-1:0] ext_cnt;
   logic [EW:0]   ext_sum;
   logic rdy_ok, armed_q, fail_q;

   xg_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
      .clk(clk), .rst_n(rst_n), .d(ext_raw), .q(ext_s));
   xg_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
      .clk(clk), .rst_n(rst_n), .d(ref_raw), .q(ref_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_p <= 1'b0;
         ref_p <= 1'b0;
      end else begin
         ext_p <= ext_s;
         ref_p <= ref_s;
      end
   end

   assign ext_rise  = ext_s & ~ext_p;
   assign ref_rise  = ref_s & ~ref_p;
   assign win_end   = en & ref_rise & (ref_cnt == REF_LAST);
   assign ext_sum   = {1'b0, ext_cnt} + {{EW{1'b0}}, ext_rise};
   assign short_win = ext_sum < EDGE_MIN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_cnt <= '0;
         ext_cnt <= '0;
         rdy_ok  <= 1'b1;
         armed_q <= 1'b0;
         fail_q  <= 1'b0;
      end else if (!en) begin
         ref_cnt <= '0;
         ext_cnt <= '0;
         rdy_ok  <= 1'b1;
         armed_q <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         fail_q <= win_end & armed_q & short_win;
         if (win_end) begin
            ref_cnt <= '0;
            ext_cnt <= '0;
            rdy_ok  <= 1'b1;
            armed_q <= armed_q | (rdy_ok & rdy);
         end else begin
            if (ref_rise) ref_cnt <= ref_cnt + 1'b1;
            if (!short_win) ext_cnt <= EW'(MIN_EDGES);
            else            ext_cnt <= ext_sum[EW-1:0];
            rdy_ok <= rdy_ok & rdy;
         end
      end
   end

   assign fail_o  = fail_q;
   assign armed_o = armed_q;

   // R9
   quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !fail_o);

   // R9
   armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> armed_o);
endmodule

// File: rtl/xg_select.sv
module xg_select
   import xosc_guard_pkg::*;
#(
   parameter bit NMI_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fail_i,
   input  logic       clr_i,
   input  logic       route_i,
   input  logic [1:0] req_i,
   output logic [1:0] sel_o,
   output logic       bypass_o,
   output logic       irq_o,
   output logic       nmi_o
);
   logic       flag_q;
   logic [1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         sel_q  <= SRC_INT;
      end else begin
         if (fail_i)     flag_q <= 1'b1;
         else if (clr_i) flag_q <= 1'b0;
         sel_q <= (fail_i || flag_q) ? SRC_INT : legal_src(req_i);
      end
   end

   generate
      if (NMI_EN) begin : g_nmi
         logic nmi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                nmi_q <= 1'b0;
            else if (fail_i && route_i) nmi_q <= 1'b1;
            else if (clr_i)            nmi_q <= 1'b0;
         end
         assign nmi_o = nmi_q;
      end else begin : g_no_nmi
         assign nmi_o = 1'b0;
      end
   endgenerate

   assign sel_o    = sel_q;
   assign bypass_o = (sel_q != SRC_PLL);
   assign irq_o    = flag_q;

   // R4
   fall_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_i |=> (sel_o == SRC_INT) && bypass_o && irq_o);

   // R5
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_i) |=> irq_o);

   // R7
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (sel_o == SRC_INT));

   // R6
   nmi_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> irq_o);
endmodule

// File: rtl/xosc_guard.sv
module xosc_guard #(
   parameter int WIN_REFS    = 64,
   parameter int MIN_EDGES   = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit NMI_EN      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mon_en,
   input  logic       ext_rdy,
   input  logic       nmi_route,
   input  logic       ext_clk_raw,
   input  logic       ref_clk_raw,
   input  logic [1:0] req_src,
   input  logic       flag_clr,
   output logic [1:0] sel_src,
   output logic       pll_bypass,
   output logic       irq_fail,
   output logic       nmi_fail
);
   generate
      if (WIN_REFS < 2) begin : g_bad_win
         $error("xosc_guard: WIN_REFS must be at least 2");
      end
      if (MIN_EDGES < 1 || MIN_EDGES > WIN_REFS * 4) begin : g_bad_min
         $error("xosc_guard: MIN_EDGES out of range");
      end
   endgenerate

   logic fail_p, armed;

   xg_window #(
      .WIN_REFS(WIN_REFS), .MIN_EDGES(MIN_EDGES), .SYNC_STAGES(SYNC_STAGES)
   ) u_window (
      .clk(clk), .rst_n(rst_n), .en(mon_en), .rdy(ext_rdy),
      .ext_raw(ext_clk_raw), .ref_raw(ref_clk_raw),
      .fail_o(fail_p), .armed_o(armed));

   xg_select #(.NMI_EN(NMI_EN)) u_select (
      .clk(clk), .rst_n(rst_n), .fail_i(fail_p), .clr_i(flag_clr),
      .route_i(nmi_route), .req_i(req_src), .sel_o(sel_src),
      .bypass_o(pll_bypass), .irq_o(irq_fail), .nmi_o(nmi_fail));

   // R4
   no_pll_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_bypass |-> !irq_fail);
endmodule

// File: tb/xosc_guard_bench.sv
module xosc_guard_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mon_en = 1'b0, ext_rdy = 1'b0, nmi_route = 1'b0;
   logic       ext_clk_raw = 1'b0, ref_clk_raw = 1'b0;
   logic [1:0] req_src = 2'd0;
   logic       flag_clr = 1'b0;
   logic [1:0] sel_src;
   logic       pll_bypass, irq_fail, nmi_fail;

   int total = 0;
   int bad = 0;
   int ext_half = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   xosc_guard u_xosc_guard (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .ext_rdy(ext_rdy),
      .nmi_route(nmi_route), .ext_clk_raw(ext_clk_raw),
      .ref_clk_raw(ref_clk_raw), .req_src(req_src), .flag_clr(flag_clr),
      .sel_src(sel_src), .pll_bypass(pll_bypass), .irq_fail(irq_fail),
      .nmi_fail(nmi_fail));

   // reference toggles every 2 cycles (period 4); external period 2*ext_half
   initial begin
      int ref_ph = 0;
      int ext_ph = 0;
      forever begin
         @(negedge clk);
         ref_ph++;
         if (ref_ph >= 2) begin ref_clk_raw = ~ref_clk_raw; ref_ph = 0; end
         if (ext_half == 0) begin
            ext_clk_raw = 1'b0; ext_ph = 0;
         end else begin
            ext_ph++;
            if (ext_ph >= ext_half) begin ext_clk_raw = ~ext_clk_raw; ext_ph = 0; end
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_irq(input int limit, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (irq_fail) begin seen = 1'b1; break; end
      end
   endtask

   task automatic pulse_clr();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 sel", sel_src, 0);
      chk("R1 bypass", pll_bypass, 1);
      chk("R1 irq", irq_fail, 0);
      chk("R1 nmi", nmi_fail, 0);
   endtask

   task automatic t_select();
      req_src = 2'd1; cycles(1);
      chk("R2 ext sel", sel_src, 1);
      chk("R2 ext bypass", pll_bypass, 1);
      req_src = 2'd2; cycles(1);
      chk("R2 pll sel", sel_src, 2);
      chk("R2 pll bypass", pll_bypass, 0);
      req_src = 2'd3; cycles(1);
      chk("R2 reserved sel", sel_src, 0);
      req_src = 2'd0; cycles(1);
      chk("R2 int sel", sel_src, 0);
   endtask

   task automatic t_startup();
      ext_half = 0;
      mon_en = 1'b0; ext_rdy = 1'b1; cycles(800);
      chk("R9 disabled no trip", irq_fail, 0);
      mon_en = 1'b1; ext_rdy = 1'b0; cycles(800);
      chk("R9 not ready no trip", irq_fail, 0);
      chk("R9 sel unchanged", sel_src, 0);
   endtask

   task automatic t_boundary();
      ext_half = 16; ext_rdy = 1'b1; req_src = 2'd2;
      cycles(1500);
      chk("R3 eight edges no trip", irq_fail, 0);
      chk("R3 pll kept", sel_src, 2);
   endtask

   task automatic t_fail_slow();
      bit seen;
      nmi_route = 1'b0; ext_half = 20;
      wait_irq(600, seen);
      chk("R4 slow clock trips", seen, 1);
      chk("R4 sel forced internal", sel_src, 0);
      chk("R4 pll bypassed", pll_bypass, 1);
      chk("R6 nmi not routed", nmi_fail, 0);
   endtask

   task automatic t_sticky();
      ext_half = 1; cycles(700);
      chk("R5 flag sticky", irq_fail, 1);
      chk("R7 pll refused", sel_src, 0);
      req_src = 2'd1; cycles(2);
      chk("R7 ext refused", sel_src, 0);
      req_src = 2'd2;
      pulse_clr();
      chk("R5 flag cleared", irq_fail, 0);
      cycles(1);
      chk("R8 pll after clear", sel_src, 2);
      chk("R8 bypass low", pll_bypass, 0);
   endtask

   task automatic t_nmi();
      bit seen;
      nmi_route = 1'b1; ext_half = 0;
      wait_irq(600, seen);
      chk("R4 dead clock trips", seen, 1);
      chk("R6 nmi raised", nmi_fail, 1);
      chk("R4 sel internal", sel_src, 0);
      ext_half = 1; cycles(700);
      chk("R6 nmi sticky", nmi_fail, 1);
      pulse_clr();
      chk("R6 nmi cleared", nmi_fail, 0);
      chk("R5 irq cleared", irq_fail, 0);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      t_reset();
      t_select();
      t_startup();
      t_boundary();
      t_fail_slow();
      t_sticky();
      t_nmi();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 200000; i++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule